// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction-Gated Pullups

This block is an eight-pin general-purpose I/O port. Three registers are visible to the processor: an output latch, a direction mask and a pullup request mask. Each is reached through a plain synchronous register interface with an address, a write strobe, write data and combinational read data. For each pin the block drives three signals to an external pad model: the value to drive, an output enable and a pullup request. It also takes the pin level back in.

A pin whose direction bit is 1 drives its latch bit onto the pad. A pin whose direction bit is 0 is an input. It is pulled high only when its pullup request bit is 1; otherwise it floats. The direction bit masks the pullup with no software step. A read of the data address gives, bit by bit, the latch for output pins and the synchronized pad level for input pins. A write to the data address always lands in the latch. Software can therefore preload a value before it turns a pin into an output.

The register interface has no valid/ready handshake. A write is taken on every rising edge where the strobe is high, and there is no back-pressure. A read needs no strobe, and the data follows the address in the same cycle.

Top module: `gpio_pullup_port`

## Requirements
- R1: After reset the latch, direction and pullup registers are all zero, so pin_oe, pin_out and pin_pull are all zero and every pin is a floating input.
- R2: Address 1 holds the direction register and address 2 holds the pullup register. A write to either one is visible on rd_data at that address from the next cycle, exactly as written.
- R3: pin_pull[i] is 1 only when pullup bit i is 1 and direction bit i is 0. A change of the direction bit changes pin_pull in the same cycle as pin_oe.
- R4: pin_oe[i] equals direction bit i, and pin_out[i] equals latch bit i.
- R5: A read of address 0 returns, for each bit, the latch bit when the direction bit is 1 and the synchronized pin level when the direction bit is 0.
- R6: A write to address 0 updates every latch bit, including the bits of input pins. The value read back from an input pin stays the pin level.
- R7: A change on pin_in appears in the address-0 read value after exactly two rising clock edges.
- R8: Address 3 is unmapped. Reads of it return zero, and writes to it change no register and no pin output.
- R9: A write changes only the register it addresses, and it takes effect at the rising edge where wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address (0 data, 1 direction, 2 pullup) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| pin_in | input | 8 | Pad levels returned from the pad model |
| pin_out | output | 8 | Value to drive on each pad |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pull | output | 8 | Per-pin pullup request |

## Verification
The checker tests four things on every cycle. A pullup is never requested on a driving pin. Writes to the latch and direction registers reach pin_out and pin_oe one edge later. Unmapped writes leave every pin output stable. Data reads of output pins match the latch, and reads of unused addresses are zero. Some behaviours only the bench's sweeps can show. These are the two-edge latency of the input path, the fact that a read of an input pin ignores a latch write, the readback of the pullup register, and the complete pullup truth table over all direction and request combinations.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int unsigned ADDR_DATA = 0;
  localparam int unsigned ADDR_DIR  = 1;
  localparam int unsigned ADDR_PULL = 2;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_reg_bank.sv
`timescale 1ns/1ps
module gpio_reg_bank
  import gpio_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pull_q
);
  logic hit_data, hit_dir, hit_pull;

  always_comb begin
    hit_data = wr_en && (addr == ADDR_W'(ADDR_DATA));
    hit_dir  = wr_en && (addr == ADDR_W'(ADDR_DIR));
    hit_pull = wr_en && (addr == ADDR_W'(ADDR_PULL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
    end else begin
      if (hit_data) latch_q <= wr_data;
      if (hit_dir)  dir_q   <= wr_data;
      if (hit_pull) pull_q  <= wr_data;
    end
  end
endmodule

// File: rtl/gpio_pin_ctl.sv
`timescale 1ns/1ps
module gpio_pin_ctl #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pull_q,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pull,
  output logic [W-1:0] data_view
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pin_out[i]   = latch_q[i];
    assign pin_oe[i]    = dir_q[i];
    assign pin_pull[i]  = pull_q[i] & ~dir_q[i];
    assign data_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
  end
endmodule

// File: rtl/gpio_pullup_port.sv
`timescale 1ns/1ps
module gpio_pullup_port
  import gpio_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pin_pull
);
  logic [W-1:0] latch_q, dir_q, pull_q, pin_sync, data_view;

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_out(pin_sync)
  );

  gpio_reg_bank #(.W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q)
  );

  gpio_pin_ctl #(.W(W)) u_pins (
    .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q), .pin_sync(pin_sync),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pull(pin_pull), .data_view(data_view)
  );

  always_comb begin
    if (addr == ADDR_W'(ADDR_DATA))      rd_data = data_view;
    else if (addr == ADDR_W'(ADDR_DIR))  rd_data = dir_q;
    else if (addr == ADDR_W'(ADDR_PULL)) rd_data = pull_q;
    else                                 rd_data = '0;
  end
endmodule

// File: rtl/gpio_pullup_port_chk.sv
`timescale 1ns/1ps
module gpio_pullup_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [W-1:0]      wr_data,
  input logic [W-1:0]      rd_data,
  input logic [W-1:0]      pin_in,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe,
  input logic [W-1:0]      pin_pull
);
  logic unmapped;
  assign unmapped = (addr != ADDR_W'(ADDR_DATA)) && (addr != ADDR_W'(ADDR_DIR)) &&
                    (addr != ADDR_W'(ADDR_PULL));

  // R3
  pull_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pull & pin_oe) == '0);

  // R4
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(ADDR_DATA)) |=> pin_out == $past(wr_data));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(ADDR_DIR)) |=> pin_oe == $past(wr_data));

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unmapped) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pull)));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> rd_data == '0);

  // R5
  out_pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(ADDR_DATA)) |-> ((rd_data ^ pin_out) & pin_oe) == '0);

  // R2
  dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(ADDR_DIR)) |-> rd_data == pin_oe);
endmodule

bind gpio_pullup_port gpio_pullup_port_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
  .pin_pull(pin_pull)
);

// File: tb/gpio_pullup_port_bench.sv
`timescale 1ns/1ps
module gpio_pullup_port_bench;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0, pin_in = '0;
  logic [W-1:0] rd_data, pin_out, pin_oe, pin_pull;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_pullup_port u_gpio_pullup_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pull(pin_pull)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    addr = a; #0.5; d = rd_data;
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    // R1: reset values, checked while reset is held and after release
    chk("R1 oe", pin_oe, 8'h00); chk("R1 out", pin_out, 8'h00); chk("R1 pull", pin_pull, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, v); chk("R1 dir", v, 8'h00);
    rd(2'd2, v); chk("R1 pull reg", v, 8'h00);
    rd(2'd0, v); chk("R1 data", v, 8'h00);

    // Sweep of every direction value with varied latch, pullup and pin patterns: R2 R3 R4 R5 R9
    for (int k = 0; k < 256; k++) begin
      logic [W-1:0] dv, pv, lv, iv;
      dv = 8'(k); pv = 8'(k * 37 + 11); lv = ~dv ^ 8'h5C; iv = 8'(k * 13 + 7);
      pin_in = iv;
      wr(2'd1, dv); wr(2'd2, pv); wr(2'd0, lv);
      @(negedge clk);
      chk("R4 oe", pin_oe, dv);
      chk("R4 out", pin_out, lv);
      chk("R3 pull", pin_pull, pv & ~dv);
      rd(2'd0, v); chk("R5 data read", v, (dv & lv) | (~dv & iv));
      rd(2'd1, v); chk("R2 dir read", v, dv);
      rd(2'd2, v); chk("R9 pull read", v, pv);
      rd(2'd3, v); chk("R8 unmapped read", v, 8'h00);
    end

    // R3: every pullup request against a fixed direction mask
    wr(2'd1, 8'h5A);
    for (int k = 0; k < 256; k++) begin
      wr(2'd2, 8'(k));
      chk("R3 pull gate", pin_pull, 8'(k) & 8'hA5);
    end
    // R3: a change of direction alone moves the pullup
    wr(2'd2, 8'hFF); wr(2'd1, 8'h0F);
    chk("R3 dir change", pin_pull, 8'hF0);

    // R6: latch write on input pins does not alter their readback
    wr(2'd1, 8'h00); pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    wr(2'd0, 8'hA5);
    rd(2'd0, v); chk("R6 input readback", v, 8'h3C);
    chk("R6 latch out", pin_out, 8'hA5);
    wr(2'd1, 8'hFF);
    rd(2'd0, v); chk("R6 preload visible", v, 8'hA5);

    // R7: two-edge latency from pin_in to data read
    wr(2'd1, 8'h00);
    @(negedge clk); pin_in = 8'hC3;
    @(negedge clk); rd(2'd0, v); chk("R7 after one edge", v, 8'h3C);
    @(negedge clk); rd(2'd0, v); chk("R7 after two edges", v, 8'hC3);

    // R8: unmapped write changes nothing
    wr(2'd1, 8'h96); wr(2'd2, 8'h3F); wr(2'd0, 8'h71);
    wr(2'd3, 8'hFF);
    wr(2'd3, 8'h00);
    chk("R8 oe", pin_oe, 8'h96); chk("R8 out", pin_out, 8'h71);
    chk("R8 pull", pin_pull, 8'h29);
    rd(2'd2, v); chk("R8 pull reg", v, 8'h3F);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule